// File: doc/BRIEF.md
# Cyclic Job Distribution Ring

This block spreads a stream of jobs over a bank of parallel worker engines. A job is an opaque word of parameterized width, typically a coordinate pair together with the index of the pixel it belongs to. The ring holds one register slot per worker. Each slot offers its job to the worker attached to it through a valid/ready pair. If that worker takes the job, the slot is empty on the next clock. If it does not, the job moves one slot further. The job in the last slot moves back into the first slot, so a job that no worker wants keeps going around the ring until some worker is free.

New jobs come in at the head slot through a valid/ready input. A job coming back from the tail always has priority over a new job, and this priority is applied only by holding the input ready low. The input ready is driven only by the tail slot's occupancy and the tail worker's ready. No other worker's ready reaches it, so a small decoupling FIFO placed upstream breaks the combinational ready chain. An option selects a stricter admission rule: input is accepted only while the tail slot is empty.

Top module: `job_ring`

## Requirements
- R1: While reset is held, and after it is released, every slot is empty. Every worker valid is low and the input ready is high.
- R2: An occupied slot whose worker has ready high hands its job to that worker in that cycle. On the next cycle the slot is empty, unless the slot before it passes a job into it.
- R3: An occupied slot whose worker has ready low moves its job, with the data unchanged, into the next slot on the next clock.
- R4: A job held by the last slot whose worker is not ready moves into the first slot (slot 0) on the next clock.
- R5: With the default admission rule, the input ready is low exactly when the last slot holds a job and its worker is not ready. In every other case it is high, including the cycle in which the tail job leaves into its worker.
- R6: A job accepted at the input (valid and ready both high) appears in slot 0 on the next clock, with its data unchanged. A job offered while ready is low is not taken and has no effect on the slots.
- R7: Every accepted job is delivered to exactly one worker, exactly once. No job is duplicated or lost, whatever pattern the worker readies follow.
- R8: Worker i sees the state of slot i: wk_valid bit i and the JOB_W-bit field of wk_data that starts at bit i*JOB_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A new job is offered |
| in_data | input | JOB_W | Job word offered |
| in_ready | output | 1 | Head slot can take the new job |
| wk_valid | output | NUM_SLOTS | Per worker: its slot holds a job |
| wk_data | output | NUM_SLOTS*JOB_W | Per worker job word, lane i at bit i*JOB_W |
| wk_ready | input | NUM_SLOTS | Per worker: it takes the offered job |

## Verification
The ring is first tried with all workers stalled. In that pattern a job must walk the full ring and wrap back to slot 0, and the input must be refused while the tail holds it. The bench then opens single workers, one at a time and in various positions. This shows a delivered job apart from a shifted one, and shows the tail-exit cycle in which the input reopens apart from the tail-stall cycle in which it stays closed. Finally a long run with random input valid and random, sparse worker readies feeds the ring numbered jobs. A scoreboard over all of them catches any job that is duplicated, lost or corrupted. A reset applied to a full ring shows that all slots empty together.

// File: rtl/jring_pkg.sv
package jring_pkg;

   // Where the head slot takes its next content from
   typedef enum logic [1:0] {
      HEAD_IDLE = 2'd0,
      HEAD_WRAP = 2'd1,
      HEAD_NEW  = 2'd2
   } head_src_e;

   // Index of the slot after slot i in a ring of n slots
   function automatic int unsigned ring_next(input int unsigned i, input int unsigned n);
      return (i == n - 1) ? 0 : i + 1;
   endfunction

endpackage

// File: rtl/jring_admit.sv
module jring_admit
   import jring_pkg::*;
#(
   parameter int JOB_W       = 32,
   parameter bit EARLY_ADMIT = 1'b1
) (
   input  logic             tail_vld,
   input  logic             tail_rdy,
   input  logic [JOB_W-1:0] tail_data,
   input  logic             in_valid,
   input  logic [JOB_W-1:0] in_data,
   output logic             in_ready,
   output logic             head_vld,
   output logic [JOB_W-1:0] head_data
);

   logic      wrap;
   head_src_e src;

   // a tail job that its worker refuses must come back to the head
   assign wrap = tail_vld & ~tail_rdy;

   generate
      if (EARLY_ADMIT) begin : g_early
         // head is free whenever nothing wraps, even while the tail job exits
         assign in_ready = ~wrap;
      end else begin : g_strict
         // head is offered only when the tail slot is empty; no ready at all
         assign in_ready = ~tail_vld;
      end
   endgenerate

   always_comb begin
      if (wrap)                     src = HEAD_WRAP;
      else if (in_valid && in_ready) src = HEAD_NEW;
      else                          src = HEAD_IDLE;
   end

   always_comb begin
      unique case (src)
         HEAD_WRAP: begin
            head_vld  = 1'b1;
            head_data = tail_data;
         end
         HEAD_NEW: begin
            head_vld  = 1'b1;
            head_data = in_data;
         end
         default: begin
            head_vld  = 1'b0;
            head_data = in_data;
         end
      endcase
   end

endmodule

// File: rtl/jring_slot.sv
module jring_slot #(
   parameter int JOB_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             up_vld,
   input  logic [JOB_W-1:0] up_data,
   input  logic             wk_rdy,
   output logic             vld,
   output logic [JOB_W-1:0] data,
   output logic             pass_vld
);

   // every occupied slot empties each cycle: into its worker or onwards,
   // so the next content is only what arrives from the predecessor
   always_ff @(posedge clk) begin
      if (rst) vld <= 1'b0;
      else     vld <= up_vld;
   end

   always_ff @(posedge clk) begin
      if (up_vld) data <= up_data;
   end

   assign pass_vld = vld & ~wk_rdy;

endmodule

// File: rtl/job_ring.sv
module job_ring
   import jring_pkg::*;
#(
   parameter int NUM_SLOTS   = 30,
   parameter int JOB_W       = 32,
   parameter bit EARLY_ADMIT = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       in_valid,
   input  logic [JOB_W-1:0]           in_data,
   output logic                       in_ready,
   output logic [NUM_SLOTS-1:0]       wk_valid,
   output logic [NUM_SLOTS*JOB_W-1:0] wk_data,
   input  logic [NUM_SLOTS-1:0]       wk_ready
);

   localparam int TAIL = NUM_SLOTS - 1;

   generate
      if (NUM_SLOTS < 2) begin : g_bad_slots
         $error("job_ring: NUM_SLOTS must be at least 2");
      end
      if (JOB_W < 1) begin : g_bad_width
         $error("job_ring: JOB_W must be at least 1");
      end
   endgenerate

   logic [NUM_SLOTS-1:0] slot_vld;
   logic [NUM_SLOTS-1:0] slot_pass;
   logic [JOB_W-1:0]     slot_data [NUM_SLOTS];
   logic [JOB_W-1:0]     up_data   [NUM_SLOTS];
   logic [NUM_SLOTS-1:0] up_vld;
   logic                 head_vld;
   logic [JOB_W-1:0]     head_data;

   jring_admit #(
      .JOB_W       (JOB_W),
      .EARLY_ADMIT (EARLY_ADMIT)
   ) u_admit (
      .tail_vld  (slot_vld[TAIL]),
      .tail_rdy  (wk_ready[TAIL]),
      .tail_data (slot_data[TAIL]),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_ready  (in_ready),
      .head_vld  (head_vld),
      .head_data (head_data)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NUM_SLOTS; gi++) begin : g_slot
         localparam int unsigned NXT = ring_next(gi, NUM_SLOTS);

         if (gi == 0) begin : g_head
            assign up_vld[gi]  = head_vld;
            assign up_data[gi] = head_data;
         end else begin : g_body
            assign up_vld[gi]  = slot_pass[gi-1];
            assign up_data[gi] = slot_data[gi-1];
         end

         jring_slot #(
            .JOB_W (JOB_W)
         ) u_slot (
            .clk      (clk),
            .rst      (rst),
            .up_vld   (up_vld[gi]),
            .up_data  (up_data[gi]),
            .wk_rdy   (wk_ready[gi]),
            .vld      (slot_vld[gi]),
            .data     (slot_data[gi]),
            .pass_vld (slot_pass[gi])
         );

         assign wk_valid[gi]                = slot_vld[gi];
         assign wk_data[gi*JOB_W +: JOB_W] = slot_data[gi];

         if (NXT >= NUM_SLOTS) begin : g_bad_next
            $error("job_ring: ring successor out of range");
         end
      end
   endgenerate

endmodule

// File: rtl/jring_chk.sv
module jring_chk #(
   parameter int NUM_SLOTS   = 30,
   parameter int JOB_W       = 32,
   parameter bit EARLY_ADMIT = 1'b1
) (
   input logic                       clk,
   input logic                       rst,
   input logic                       in_valid,
   input logic [JOB_W-1:0]           in_data,
   input logic                       in_ready,
   input logic [NUM_SLOTS-1:0]       wk_valid,
   input logic [NUM_SLOTS*JOB_W-1:0] wk_data,
   input logic [NUM_SLOTS-1:0]       wk_ready
);

   localparam int TAIL = NUM_SLOTS - 1;

   AST_JOB_CONSERVED: assert property (@(posedge clk) disable iff (rst)
      !rst |=> ($countones(wk_valid) == $countones($past(wk_valid))
                - $countones($past(wk_valid & wk_ready))
                + int'($past(in_valid & in_ready)))); // R7

   AST_WRAP_TO_HEAD: assert property (@(posedge clk) disable iff (rst)
      (wk_valid[TAIL] && !wk_ready[TAIL]) |=>
         (wk_valid[0] && wk_data[0 +: JOB_W] == $past(wk_data[TAIL*JOB_W +: JOB_W]))); // R4

   AST_ACCEPT_HEAD: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready) |=>
         (wk_valid[0] && wk_data[0 +: JOB_W] == $past(in_data))); // R6

   AST_TAIL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
      (wk_valid[TAIL] && !wk_ready[TAIL]) |-> !in_ready); // R5

   AST_EMPTY_TAIL_OPEN: assert property (@(posedge clk) disable iff (rst)
      !wk_valid[TAIL] |-> in_ready); // R5

   generate
      if (EARLY_ADMIT) begin : g_early
         AST_TAIL_EXIT_OPEN: assert property (@(posedge clk) disable iff (rst)
            (wk_valid[TAIL] && wk_ready[TAIL]) |-> in_ready); // R5
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < NUM_SLOTS; gi++) begin : g_lane
         if (gi < TAIL) begin : g_fwd
            AST_STALL_ADVANCE: assert property (@(posedge clk) disable iff (rst)
               (wk_valid[gi] && !wk_ready[gi]) |=>
                  (wk_valid[gi+1] &&
                   wk_data[(gi+1)*JOB_W +: JOB_W] == $past(wk_data[gi*JOB_W +: JOB_W]))); // R3
         end
         if (gi == 0) begin : g_head
            AST_TAKEN_EMPTIES: assert property (@(posedge clk) disable iff (rst)
               (wk_valid[0] && wk_ready[0] && !(wk_valid[TAIL] && !wk_ready[TAIL])
                && !(in_valid && in_ready)) |=> !wk_valid[0]); // R2
         end else begin : g_body
            AST_TAKEN_EMPTIES: assert property (@(posedge clk) disable iff (rst)
               (wk_valid[gi] && wk_ready[gi] && !(wk_valid[gi-1] && !wk_ready[gi-1]))
                  |=> !wk_valid[gi]); // R2
         end
      end
   endgenerate

endmodule

bind job_ring jring_chk #(
   .NUM_SLOTS   (NUM_SLOTS),
   .JOB_W       (JOB_W),
   .EARLY_ADMIT (EARLY_ADMIT)
) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .in_data  (in_data),
   .in_ready (in_ready),
   .wk_valid (wk_valid),
   .wk_data  (wk_data),
   .wk_ready (wk_ready)
);

// File: tb/tb_job_ring.sv
module tb_job_ring;

   localparam int N = 4;
   localparam int W = 12;
   localparam int NVEC = 10;
   localparam int VW = 1 + W + N + 1 + N + N*W;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic           in_valid = 1'b0;
   logic [W-1:0]   in_data = '0;
   logic           in_ready;
   logic [N-1:0]   wk_valid;
   logic [N*W-1:0] wk_data;
   logic [N-1:0]   wk_ready = '0;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   job_ring #(.NUM_SLOTS(N), .JOB_W(W), .EARLY_ADMIT(1'b1)) dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .wk_valid(wk_valid), .wk_data(wk_data),
      .wk_ready(wk_ready)
   );

   // {in_valid, in_data, wk_ready, exp in_ready, exp wk_valid, exp data {s3,s2,s1,s0}}
   localparam logic [VW-1:0] VEC [NVEC] = '{
      {1'b1, 12'h0A1, 4'b0000, 1'b1, 4'b0000, 48'h000000000000}, // R6 empty ring takes A1
      {1'b1, 12'h0A2, 4'b0000, 1'b1, 4'b0001, 48'h0000000000A1}, // R6 R8
      {1'b0, 12'h000, 4'b0000, 1'b1, 4'b0011, 48'h0000000A10A2}, // R3
      {1'b0, 12'h000, 4'b0000, 1'b1, 4'b0110, 48'h0000A10A2000}, // R3
      {1'b1, 12'h0A3, 4'b0000, 1'b0, 4'b1100, 48'h0A10A2000000}, // R5 tail stalls, A3 refused
      {1'b1, 12'h0A3, 4'b1000, 1'b1, 4'b1001, 48'h0A20000000A1}, // R4 wrap seen, R5 tail exits
      {1'b0, 12'h000, 4'b0010, 1'b1, 4'b0011, 48'h0000000A10A3}, // R2 worker 1 takes A1
      {1'b1, 12'h0A4, 4'b0001, 1'b1, 4'b0010, 48'h0000000A3000}, // R2 empty slot 0 gives nothing
      {1'b0, 12'h000, 4'b0101, 1'b1, 4'b0101, 48'h0000A30000A4}, // R2 two takes
      {1'b0, 12'h000, 4'b0000, 1'b1, 4'b0000, 48'h000000000000}  // R2 ring empty again
   };

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   bit seen [4096];
   int next_id = 0;

   task automatic record_deliveries();
      for (int l = 0; l < N; l++) begin
         if (wk_valid[l] && wk_ready[l]) begin
            int id;
            id = int'(wk_data[l*W +: W]);
            check(id < next_id, "R7 delivered id out of range", 64'(id), 64'(next_id));
            check(!seen[id], "R7 duplicate delivery", 64'(id), 64'(id));
            seen[id] = 1'b1;
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      #1;
      check(wk_valid == '0, "R1 valids in reset", 64'(wk_valid), 64'(0));
      check(in_ready == 1'b1, "R1 ready in reset", 64'(in_ready), 64'(1));
      rst = 1'b0;

      // table walk
      for (int k = 0; k < NVEC; k++) begin
         logic [VW-1:0] v;
         logic [N*W-1:0] ewd;
         logic [N-1:0]   ewv;
         @(negedge clk);
         v = VEC[k];
         {in_valid, in_data, wk_ready} = v[VW-1 -: 1 + W + N];
         ewv = v[N*W +: N];
         ewd = v[N*W-1:0];
         #1;
         check(in_ready == v[N*W + N], "R5 in_ready", 64'(in_ready), 64'(v[N*W + N]));
         check(wk_valid == ewv, "R3 R4 R6 wk_valid", 64'(wk_valid), 64'(ewv));
         for (int l = 0; l < N; l++)
            if (ewv[l])
               check(wk_data[l*W +: W] == ewd[l*W +: W], "R8 lane data",
                     64'(wk_data[l*W +: W]), 64'(ewd[l*W +: W]));
      end

      // scoreboard run with random valid and sparse readies
      for (int c = 0; c < 2000; c++) begin
         @(negedge clk);
         in_valid = (next_id < 4000) && ($urandom_range(0, 1) == 1);
         in_data  = W'(next_id);
         for (int l = 0; l < N; l++) wk_ready[l] = ($urandom_range(0, 3) == 0);
         #1;
         record_deliveries();
         if (in_valid && in_ready) next_id++;
      end
      @(negedge clk);
      in_valid = 1'b0;
      wk_ready = '1;
      for (int c = 0; c < 3 * N; c++) begin
         #1;
         record_deliveries();
         @(negedge clk);
      end
      #1;
      check(wk_valid == '0, "R7 ring drained", 64'(wk_valid), 64'(0));
      begin
         int missing = 0;
         for (int i = 0; i < next_id; i++) if (!seen[i]) missing++;
         check(missing == 0, "R7 jobs lost", 64'(missing), 64'(0));
      end
      check(next_id > 100, "R7 enough jobs accepted", 64'(next_id), 64'(100));

      // fill the ring with workers stalled, then reset it
      wk_ready = '0;
      for (int c = 0; c < N; c++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = W'(c);
      end
      @(negedge clk);
      in_valid = 1'b0;
      #1;
      check(wk_valid == '1, "R3 ring full", 64'(wk_valid), 64'hF);
      check(in_ready == 1'b0, "R5 full ring refuses", 64'(in_ready), 64'(0));
      rst = 1'b1;
      @(negedge clk);
      #1;
      check(wk_valid == '0, "R1 reset empties ring", 64'(wk_valid), 64'(0));
      check(in_ready == 1'b1, "R1 ready after reset", 64'(in_ready), 64'(1));
      rst = 1'b0;
      @(negedge clk);
      #1;
      check(wk_valid == '0, "R1 empty after release", 64'(wk_valid), 64'(0));

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule